// File: doc/BRIEF.md
# DDR Write Strobe and Data Driver

This block sits on the controller side of a double-data-rate SDRAM interface and drives the write strobe and data lanes for write bursts. A write command is issued together with a burst-length code. The block then enables the strobe and holds it low for one half-cycle as a lead-in. After that it toggles the strobe once per data element, high for the first element of each pair and low for the second. When the burst ends it holds the strobe low for one more half-cycle and then releases both strobe and data to high impedance.

The output is modelled at half-clock resolution. Each bus is presented as two phase slots per clock cycle: bit/slot 0 is the first half of the cycle and bit/slot 1 is the second half. Tri-state is represented by per-phase output enables. Write data is pulled from the source one pair per cycle through a pull strobe. A command whose spacing from the previous one equals that burst's number of pairs makes the strobe keep toggling with no lead-in or trailing half-cycle between the bursts. An earlier command cuts the running burst short.

Top module: `ddr_wr_drive`

## Requirements
- R1: While reset is active and until the first command, all output enables, the strobe, data, mask and `wdata_pull` are 0.
- R2: In the cycle after the command cycle (the lead cycle), when no data cycle is active, `strobe_oe` is 2'b11 and `strobe` is 2'b00. This means the enable comes on one phase before the low lead-in phase. `dout_oe` stays 2'b00.
- R3: The first data cycle of a burst is the second cycle after the command cycle. Its phase 0 carries the first rising strobe half, which is one clock after the nominal strobe position plus one output register stage.
- R4: In every data cycle `strobe` is 2'b01, `strobe_oe` and `dout_oe` are 2'b11. `dout[DW-1:0]` carries the even element (phase 0) and `dout[2*DW-1:DW]` the odd element (phase 1).
- R5: `bl_sel` encodes the burst: 0 gives 2 elements (1 data cycle), 1 gives 4 (2 cycles), 2 and 3 give 8 (4 cycles).
- R6: `wdata_pull` is 1 exactly in the cycle before each data cycle. The `wdata`/`wmask` pair present in that cycle is what appears in the next data cycle.
- R7: `dmask` carries the `wmask` bit of each element in data cycles (bit 0 with phase 0) and is 2'b00 in every other cycle.
- R8: In the cycle after the last data cycle, with no data continuing, `strobe_oe` is 2'b01 and `strobe` is 2'b00 (trailing low half-cycle).
- R9: After the trailing half-cycle, with no command pending, `strobe_oe` and `dout_oe` are 2'b00.
- R10: A command issued N cycles after a previous N-pair command gives contiguous data cycles, with no trailing or lead-in phase between them.
- R11: With a one-cycle gap between bursts, the trailing and lead-in phases merge into one cycle with `strobe_oe` 2'b11 and `strobe` 2'b00.
- R12: A command issued before the previous burst completes truncates it. Data cycles of the new burst start two cycles after the new command, and the old remaining pairs are dropped.
- R13: `bl_sel` is sampled only in the command cycle. Changes to it in later cycles do not alter the running burst length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_cmd | input | 1 | Write command, one cycle per command |
| bl_sel | input | 2 | Burst length code, sampled with `wr_cmd` |
| wdata | input | 2*DW | Data pair, element 0 in low half |
| wmask | input | 2 | Mask bits for the pair, bit 0 for element 0 |
| wdata_pull | output | 1 | Source must present the next pair in this cycle |
| strobe | output | 2 | Strobe level per phase |
| strobe_oe | output | 2 | Strobe output enable per phase |
| dout | output | 2*DW | Data per phase |
| dout_oe | output | 2 | Data output enable per phase |
| dmask | output | 2 | Mask bit per phase |

## Verification
The bench targets the seams between bursts.
- Exact-spacing back-to-back commands: a design that failed to merge them would insert a trailing low phase mid-stream.
- One-cycle gaps: a design that got these wrong would drop the strobe enable for a phase instead of fusing trailing and lead-in.
- Early commands that truncate a burst: a design mishandling these would keep streaming old pairs or restart late.
- Changing the length code after the command: this catches a design that reads it live.
- The pairing of pull with data: an off-by-one here shifts every element one cycle.

// File: rtl/ddrw_pkg.sv
package ddrw_pkg;

  typedef enum logic [1:0] {
    BLEN_2  = 2'd0,
    BLEN_4  = 2'd1,
    BLEN_8  = 2'd2,
    BLEN_8B = 2'd3
  } blen_e;

  // number of data cycles (element pairs) for a length code
  function automatic int pairs_for(input logic [1:0] code);
    case (blen_e'(code))
      BLEN_2:  pairs_for = 1;
      BLEN_4:  pairs_for = 2;
      default: pairs_for = 4;
    endcase
  endfunction

endpackage

// File: rtl/ddrw_burst_ctl.sv
module ddrw_burst_ctl
  import ddrw_pkg::*;
#(
  parameter int MAX_PAIRS = 4,
  localparam int CNT_W = $clog2(MAX_PAIRS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_cmd,
  input  logic [1:0] bl_sel,
  output logic       lead_o,
  output logic       data_o,
  output logic       tail_o,
  output logic       pull_o
);

  logic             lead_q, lead_n;
  logic [CNT_W-1:0] pend_q, pend_n;
  logic [CNT_W-1:0] rem_q,  rem_n;
  logic             tail_q, tail_n;
  logic             pend_en;

  // next-state
  always_comb begin
    lead_n  = wr_cmd;
    pend_en = wr_cmd;
    pend_n  = CNT_W'(pairs_for(bl_sel));
    if (lead_q) begin
      rem_n = pend_q;
    end else if (rem_q != '0) begin
      rem_n = rem_q - CNT_W'(1);
    end else begin
      rem_n = '0;
    end
    tail_n = (rem_q == CNT_W'(1)) && !lead_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_q <= 1'b0;
      pend_q <= '0;
      rem_q  <= '0;
      tail_q <= 1'b0;
    end else begin
      lead_q <= lead_n;
      if (pend_en) pend_q <= pend_n;
      rem_q  <= rem_n;
      tail_q <= tail_n;
    end
  end

  assign lead_o = lead_q;
  assign data_o = (rem_q != '0);
  assign tail_o = tail_q;
  assign pull_o = lead_q || (rem_q > CNT_W'(1));

  AST_LEAD_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    lead_q |=> (rem_q != '0));                                   // R3
  AST_PULL_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    pull_o |=> data_o);                                          // R6
  AST_TAIL_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    tail_q |-> ($past(rem_q) == CNT_W'(1) && rem_q == '0));      // R8

endmodule

// File: rtl/ddrw_phase_gen.sv
module ddrw_phase_gen (
  input  logic       lead_i,
  input  logic       data_i,
  input  logic       tail_i,
  output logic [1:0] strobe_o,
  output logic [1:0] strobe_oe_o
);

  always_comb begin
    if (data_i) begin
      strobe_o    = 2'b01;
      strobe_oe_o = 2'b11;
    end else begin
      strobe_o    = 2'b00;
      strobe_oe_o = {lead_i, lead_i | tail_i};
    end
  end

endmodule

// File: rtl/ddrw_data_lane.sv
module ddrw_data_lane #(
  parameter int DW = 8,
  localparam int PH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pull_i,
  input  logic            data_i,
  input  logic [PH*DW-1:0] wdata_i,
  input  logic [PH-1:0]   wmask_i,
  output logic [PH*DW-1:0] dout_o,
  output logic [PH-1:0]   dmask_o,
  output logic [PH-1:0]   dout_oe_o
);

  for (genvar p = 0; p < PH; p++) begin : g_phase
    logic [DW-1:0] el_q, el_n;
    logic          mk_q, mk_n;

    always_comb begin
      el_n = wdata_i[p*DW +: DW];
      mk_n = wmask_i[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        el_q <= '0;
        mk_q <= 1'b0;
      end else if (pull_i) begin
        el_q <= el_n;
        mk_q <= mk_n;
      end
    end

    assign dout_o[p*DW +: DW] = data_i ? el_q : '0;
    assign dmask_o[p]         = data_i & mk_q;
    assign dout_oe_o[p]       = data_i;
  end

endmodule

// File: rtl/ddr_wr_drive.sv
module ddr_wr_drive #(
  parameter int DW        = 8,
  parameter int MAX_PAIRS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cmd,
  input  logic [1:0]    bl_sel,
  input  logic [2*DW-1:0] wdata,
  input  logic [1:0]    wmask,
  output logic          wdata_pull,
  output logic [1:0]    strobe,
  output logic [1:0]    strobe_oe,
  output logic [2*DW-1:0] dout,
  output logic [1:0]    dout_oe,
  output logic [1:0]    dmask
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic lead, data, tail;

  ddrw_burst_ctl #(.MAX_PAIRS(MAX_PAIRS)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .wr_cmd (wr_cmd),
    .bl_sel (bl_sel),
    .lead_o (lead),
    .data_o (data),
    .tail_o (tail),
    .pull_o (wdata_pull)
  );

  ddrw_phase_gen u_phase (
    .lead_i      (lead),
    .data_i      (data),
    .tail_i      (tail),
    .strobe_o    (strobe),
    .strobe_oe_o (strobe_oe)
  );

  ddrw_data_lane #(.DW(DW)) u_lane (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .pull_i    (wdata_pull),
    .data_i    (data),
    .wdata_i   (wdata),
    .wmask_i   (wmask),
    .dout_o    (dout),
    .dmask_o   (dmask),
    .dout_oe_o (dout_oe)
  );

  AST_DATA_UNDER_STROBE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (dout_oe != 2'b00) |-> (strobe_oe == 2'b11 && strobe == 2'b01));   // R4
  AST_QUIET_WHEN_RELEASED: assert property (@(posedge clk) disable iff (!rst_core_n)
    (strobe_oe == 2'b00) |-> (dout_oe == 2'b00 && dmask == 2'b00));    // R9
  AST_MASK_IN_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_core_n)
    (dmask != 2'b00) |-> (dout_oe == 2'b11));                          // R7
  AST_CMD_LEADS_ENABLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_cmd |=> (strobe_oe == 2'b11));                                  // R2

endmodule

// File: tb/sim_ddr_wr_drive.sv
`timescale 1ns/1ps
module sim_ddr_wr_drive;

  localparam int DW = 8;
  localparam int T  = 70;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_cmd;
  logic [1:0]    bl_sel;
  logic [2*DW-1:0] wdata;
  logic [1:0]    wmask;
  logic          wdata_pull;
  logic [1:0]    strobe, strobe_oe, dout_oe, dmask;
  logic [2*DW-1:0] dout;

  always #10 clk = ~clk;

  ddr_wr_drive #(.DW(DW), .MAX_PAIRS(4)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .bl_sel(bl_sel),
    .wdata(wdata), .wmask(wmask), .wdata_pull(wdata_pull),
    .strobe(strobe), .strobe_oe(strobe_oe), .dout(dout),
    .dout_oe(dout_oe), .dmask(dmask)
  );

  typedef struct {
    int              cyc;
    logic [1:0]      stb, stb_oe, d_oe, mk;
    logic [2*DW-1:0] d;
    logic            pull;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   cmd_v [0:T+9];
  logic [1:0] cmd_bl [0:T+9];

  function automatic int pairs_of(logic [1:0] b);
    if (b == 2'd0) return 1;
    if (b == 2'd1) return 2;
    return 4;
  endfunction

  function automatic bit is_data(int t);
    for (int ci = t - 2; ci >= 0; ci--)
      if (cmd_v[ci]) return (t <= ci + 1 + pairs_of(cmd_bl[ci]));
    return 1'b0;
  endfunction

  function automatic bit is_lead(int t);
    return (t >= 1) && cmd_v[t-1];
  endfunction

  function automatic bit is_tail(int t);
    return (t >= 1) && !is_data(t) && is_data(t-1);
  endfunction

  function automatic logic [2*DW-1:0] wd(int t);
    return {8'(t*7 + 3), 8'(t*13 + 1)};
  endfunction

  function automatic logic [1:0] wm(int t);
    return 2'(t ^ (t >> 2));
  endfunction

  function automatic string scen_tag(int t);
    if (t < 3)  return "R1";
    if (t < 12) return "R3";
    if (t < 20) return "R5";
    if (t < 34) return "R10";
    if (t < 44) return "R11";
    if (t < 56) return "R12";
    return "R13";
  endfunction

  task automatic chk(string tag, string what, int cyc, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s cycle %0d actual=%h expected=%h", tag, what, cyc, act, exp);
    end
  endtask

  // monitor: pops one expected item per cycle, compares away from the edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      string st;
      e = q.pop_front();
      if (is_data(e.cyc))      st = "R4";
      else if (is_lead(e.cyc)) st = "R2";
      else if (is_tail(e.cyc)) st = "R8";
      else                     st = (e.cyc < 3) ? "R1" : "R9";
      chk(scen_tag(e.cyc), "strobe",    e.cyc, 32'(strobe),    32'(e.stb));
      chk(st,              "strobe_oe", e.cyc, 32'(strobe_oe), 32'(e.stb_oe));
      chk(scen_tag(e.cyc), "dout_oe",   e.cyc, 32'(dout_oe),   32'(e.d_oe));
      chk("R4",            "dout",      e.cyc, 32'(dout),      32'(e.d));
      chk("R7",            "dmask",     e.cyc, 32'(dmask),     32'(e.mk));
      chk("R6",            "pull",      e.cyc, 32'(wdata_pull), 32'(e.pull));
    end
  end

  // driver
  initial begin
    for (int i = 0; i < T + 10; i++) begin
      cmd_v[i]  = 1'b0;
      cmd_bl[i] = 2'd0;
    end
    cmd_v[3]  = 1'b1; cmd_bl[3]  = 2'd1;   // single 4-element burst
    cmd_v[12] = 1'b1; cmd_bl[12] = 2'd0;   // R5: 2 elements
    cmd_v[20] = 1'b1; cmd_bl[20] = 2'd2;   // R10: 8 elements then
    cmd_v[24] = 1'b1; cmd_bl[24] = 2'd1;   //      seamless 4
    cmd_v[34] = 1'b1; cmd_bl[34] = 2'd0;   // R11: one-cycle gap
    cmd_v[36] = 1'b1; cmd_bl[36] = 2'd0;
    cmd_v[44] = 1'b1; cmd_bl[44] = 2'd3;   // R12: code 3, truncated
    cmd_v[46] = 1'b1; cmd_bl[46] = 2'd0;
    cmd_v[56] = 1'b1; cmd_bl[56] = 2'd1;   // R13: code varies afterwards

    rst_n = 1'b0; wr_cmd = 1'b0; bl_sel = 2'd0; wdata = '0; wmask = '0;
    repeat (3) @(posedge clk);
    #5;
    chk("R1", "reset strobe_oe", -1, 32'(strobe_oe), 32'd0);
    chk("R1", "reset dout_oe",   -1, 32'(dout_oe),   32'd0);
    chk("R1", "reset pull",      -1, 32'(wdata_pull), 32'd0);
    chk("R1", "reset dmask",     -1, 32'(dmask),     32'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int t = 0; t < T; t++) begin
      exp_t e;
      bit dd;
      @(posedge clk);
      #1;
      wr_cmd = cmd_v[t];
      bl_sel = cmd_v[t] ? cmd_bl[t] : 2'(t);
      wdata  = wd(t);
      wmask  = wm(t);
      dd       = is_data(t);
      e.cyc    = t;
      e.stb    = dd ? 2'b01 : 2'b00;
      e.stb_oe = dd ? 2'b11 : {is_lead(t), is_lead(t) | is_tail(t)};
      e.d_oe   = dd ? 2'b11 : 2'b00;
      e.d      = dd ? wd(t-1) : '0;
      e.mk     = dd ? wm(t-1) : 2'b00;
      e.pull   = is_data(t + 1);
      q.push_back(e);
    end
    @(posedge clk);
    #1;
    wr_cmd = 1'b0;
    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule